// File: doc/BRIEF.md
# N-tuple filter hash generator

This block turns a 32-bit key, already reduced from the fields of a packet n-tuple, into two 16-bit values used to search an open-addressed filter table. The first is a hash that names the first candidate slot. The second is an odd stride for collision resolution. Because the stride is odd, repeated probing from the first slot visits every slot of any power-of-two table. The hash is a two-stage folded form of the LFSR x^16 + x^3 + 1, seeded with 0x1fff. It must match a software model bit for bit.

Keys enter and results leave on valid/ready streams. A key is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is handed over on an edge where `out_valid` and `out_ready` are both high.

With `REG_OUT = 1`, one output register holds a single result. While that result is held and not taken, the outputs do not change and `in_ready` stays low, so back-pressure reaches the source at once. With `REG_OUT = 0`, the block is purely combinational and ready passes straight through.

Top module: `nth_hash_gen`

## Requirements
- R1: The first fold value is s = F(0x1fff XOR key[31:16]). Here F(v) takes a = v ^ (v>>3) ^ (v>>6) and returns a ^ (a>>9). Every shift, XOR and result is truncated to 16 bits.
- R2: `out_hash` is F(s ^ (s<<13) ^ key[15:0]), with all values truncated to 16 bits.
- R3: `out_incr` equals (key*2 - 1) truncated to 16 bits, so key 0 gives 0xFFFF.
- R4: Bit 0 of `out_incr` is 1 for every key.
- R5: With REG_OUT=1, a key accepted at an edge appears on the outputs, with `out_valid` high, right after that same edge.
- R6: With REG_OUT=1, while `out_valid` is high and `out_ready` is low, `out_valid`, `out_hash` and `out_incr` hold their values.
- R7: With REG_OUT=1, `in_ready` is high exactly when the output register is empty or `out_ready` is high.
- R8: With REG_OUT=0, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and both results are functions of the current `in_key` in the same cycle.
- R9: During reset and on the first cycle after it, `out_valid` is low and `in_ready` is high (REG_OUT=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A key is offered |
| in_ready | output | 1 | The block takes the offered key at this edge |
| in_key | input | 32 | N-tuple key |
| out_valid | output | 1 | Results are present |
| out_ready | input | 1 | The consumer takes the results at this edge |
| out_hash | output | 16 | First candidate slot hash |
| out_incr | output | 16 | Odd probe stride |

## Verification
The bench builds two copies of the block side by side, one with REG_OUT=1 and one with REG_OUT=0, and feeds both the same key stream and the same `out_ready` pattern.

The registered copy exercises the latency, hold-under-stall and ready rules. Random back-pressure forces long runs of held results, and each held result is compared against a queue of expected values.

The combinational copy is compared in the same cycle as its input. This shows that both variants compute identical values, including the corner keys 0, 0xFFFFFFFF, 0x0000FFFF and 0xFFFF0000.

// File: rtl/nth_hash_pkg.sv
package nth_hash_pkg;
  localparam int KEY_W  = 32;
  localparam int HASH_W = KEY_W / 2;
  localparam logic [HASH_W-1:0] HASH_SEED = 16'h1fff;
  localparam int SHIFT_A   = 3;
  localparam int SHIFT_B   = 6;
  localparam int SHIFT_C   = 9;
  localparam int SHIFT_MIX = 13;

  typedef logic [HASH_W-1:0] hword_t;

  typedef struct packed {
    hword_t hash;
    hword_t incr;
  } hash_res_t;
endpackage

// File: rtl/nth_fold.sv
module nth_fold
  import nth_hash_pkg::*;
(
  input  hword_t v_in,
  output hword_t v_out
);
  hword_t stage_a;

  always_comb begin
    stage_a = v_in ^ (v_in >> SHIFT_A) ^ (v_in >> SHIFT_B);
    v_out   = stage_a ^ (stage_a >> SHIFT_C);
  end
endmodule

// File: rtl/nth_hash_core.sv
module nth_hash_core
  import nth_hash_pkg::*;
(
  input  logic [KEY_W-1:0] key,
  output hword_t           hash
);
  localparam int NSTAGE = 2;

  hword_t fold_in  [NSTAGE];
  hword_t fold_out [NSTAGE];
  hword_t key_half [NSTAGE];

  assign key_half[0] = key[KEY_W-1:HASH_W];
  assign key_half[1] = key[HASH_W-1:0];

  assign fold_in[0] = HASH_SEED ^ key_half[0];
  assign fold_in[1] = fold_out[0] ^ hword_t'(fold_out[0] << SHIFT_MIX) ^ key_half[1];

  for (genvar g = 0; g < NSTAGE; g++) begin : g_fold
    nth_fold fold_i (.v_in(fold_in[g]), .v_out(fold_out[g]));
  end

  assign hash = fold_out[NSTAGE-1];
endmodule

// File: rtl/nth_incr.sv
module nth_incr
  import nth_hash_pkg::*;
(
  input  logic [KEY_W-1:0] key,
  output hword_t           incr
);
  hword_t doubled;

  assign doubled = {key[HASH_W-2:0], 1'b0};
  assign incr    = doubled - hword_t'(1);
endmodule

// File: rtl/nth_out_stage.sv
module nth_out_stage
  import nth_hash_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      s_valid,
  output logic      s_ready,
  input  hash_res_t s_data,
  output logic      m_valid,
  input  logic      m_ready,
  output hash_res_t m_data
);
  if (REG_OUT) begin : g_reg
    logic      held_v;
    hash_res_t held_d;

    assign s_ready = !held_v || m_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held_v <= 1'b0;
        held_d <= '0;
      end else if (s_ready) begin
        held_v <= s_valid;
        if (s_valid) held_d <= s_data;
      end
    end

    assign m_valid = held_v;
    assign m_data  = held_d;
  end else begin : g_comb
    assign s_ready = m_ready;
    assign m_valid = s_valid;
    assign m_data  = s_data;
  end
endmodule

// File: rtl/nth_hash_gen.sv
module nth_hash_gen
  import nth_hash_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [KEY_W-1:0]  in_key,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HASH_W-1:0] out_hash,
  output logic [HASH_W-1:0] out_incr
);
  hash_res_t res_c;
  hash_res_t res_q;

  nth_hash_core core_i (.key(in_key), .hash(res_c.hash));
  nth_incr      incr_i (.key(in_key), .incr(res_c.incr));

  nth_out_stage #(.REG_OUT(REG_OUT)) out_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (res_c),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (res_q)
  );

  assign out_hash = res_q.hash;
  assign out_incr = res_q.incr;
endmodule

// File: rtl/nth_hash_gen_chk.sv
module nth_hash_gen_chk #(
  parameter bit REG_OUT = 1'b1,
  parameter int HW      = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [HW-1:0] out_hash,
  input logic [HW-1:0] out_incr
);
  // R4
  incr_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_incr[0]);

  if (REG_OUT) begin : g_reg_chk
    // R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_hash) && $stable(out_incr)));
    // R7
    empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);
  end else begin : g_comb_chk
    // R8
    pass_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == in_valid) && (in_ready == out_ready));
  end
endmodule

bind nth_hash_gen nth_hash_gen_chk #(.REG_OUT(REG_OUT), .HW(nth_hash_pkg::HASH_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_hash  (out_hash),
  .out_incr  (out_incr)
);

// File: tb/nth_hash_gen_tb_top.sv
`timescale 1ns/1ps
module nth_hash_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_key = '0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid;
  logic [15:0] out_hash, out_incr;
  logic        in_ready_c, out_valid_c;
  logic [15:0] out_hash_c, out_incr_c;

  int checks = 0;
  int errors = 0;
  bit rnd_ready = 1'b0;
  bit fixed_ready = 1'b1;
  bit finished = 1'b0;
  logic [31:0] exp_q [$];

  always #10 clk = ~clk;

  nth_hash_gen #(.REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .out_valid(out_valid), .out_ready(out_ready),
    .out_hash(out_hash), .out_incr(out_incr));

  nth_hash_gen #(.REG_OUT(1'b0)) dut_c_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_c),
    .in_key(in_key), .out_valid(out_valid_c), .out_ready(out_ready),
    .out_hash(out_hash_c), .out_incr(out_incr_c));

  function automatic logic [15:0] m_fold(input logic [15:0] v);
    logic [15:0] a;
    a = v ^ (v >> 3) ^ (v >> 6);
    return a ^ (a >> 9);
  endfunction

  function automatic logic [15:0] m_hash(input logic [31:0] k);
    logic [15:0] s, t;
    s = m_fold(16'h1fff ^ k[31:16]);
    t = s ^ 16'(s << 13) ^ k[15:0];
    return m_fold(t);
  endfunction

  function automatic logic [15:0] m_incr(input logic [31:0] k);
    logic [31:0] w;
    w = k * 32'd2 - 32'd1;
    return w[15:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rnd_ready) out_ready <= ($urandom_range(0, 3) != 0);
    else out_ready <= fixed_ready;
  end

  // Monitor: pops the scoreboard whenever the registered copy hands over a result
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected result", {16'h0, out_hash}, 32'h0);
      end else begin
        logic [31:0] k;
        k = exp_q.pop_front();
        chk(out_hash == m_hash(k), "R1/R2 hash", {16'h0, out_hash}, {16'h0, m_hash(k)});
        chk(out_incr == m_incr(k), "R3 incr", {16'h0, out_incr}, {16'h0, m_incr(k)});
        chk(out_incr[0], "R4 odd incr", {31'h0, out_incr[0]}, 32'h1);
      end
    end
  end

  // Driver: offers one key until it is taken, pushing the expected item on acceptance
  task automatic send(input logic [31:0] k);
    bit acc;
    in_valid = 1'b1;
    in_key = k;
    forever begin
      #1;
      acc = in_ready;
      chk(out_hash_c == m_hash(k), "R8 comb hash", {16'h0, out_hash_c}, {16'h0, m_hash(k)});
      chk(out_incr_c == m_incr(k), "R8 comb incr", {16'h0, out_incr_c}, {16'h0, m_incr(k)});
      chk(out_valid_c == 1'b1 && in_ready_c == out_ready, "R8 comb handshake",
          {30'h0, out_valid_c, in_ready_c}, {30'h0, 1'b1, out_ready});
      if (acc) exp_q.push_back(k);
      @(negedge clk);
      if (acc) break;
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] corners [4];
    logic [15:0] h_hold, i_hold;
    corners[0] = 32'h0000_0000;
    corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h0000_FFFF;
    corners[3] = 32'hFFFF_0000;

    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R9 valid in reset", {31'h0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R9 after reset",
        {30'h0, out_valid, in_ready}, 32'h1);
    @(negedge clk);

    // R3 boundary: key 0 gives stride 0xFFFF
    chk(m_incr(32'h0) == 16'hFFFF, "R3 model key0", {16'h0, m_incr(32'h0)}, 32'hFFFF);

    // R5: one key with the consumer ready
    send(32'h1234_5678);
    #3;
    chk(out_valid == 1'b1, "R5 latency", {31'h0, out_valid}, 32'h1);
    @(negedge clk);
    #3;
    chk(out_valid == 1'b0, "R5 drained", {31'h0, out_valid}, 32'h0);
    @(negedge clk);

    // R6/R7: stall with the consumer not ready
    fixed_ready = 1'b0;
    @(negedge clk);
    send(32'hDEAD_BEEF);
    #3;
    chk(out_valid == 1'b1 && in_ready == 1'b0, "R7 full and stalled",
        {30'h0, out_valid, in_ready}, 32'h2);
    h_hold = out_hash;
    i_hold = out_incr;
    repeat (3) @(negedge clk);
    #3;
    chk(out_valid && out_hash == h_hold && out_incr == i_hold, "R6 hold",
        {out_hash, out_incr}, {h_hold, i_hold});
    chk(out_hash == m_hash(32'hDEAD_BEEF), "R6 held value", {16'h0, out_hash},
        {16'h0, m_hash(32'hDEAD_BEEF)});
    fixed_ready = 1'b1;
    @(negedge clk);
    #3;
    chk(in_ready == 1'b1, "R7 ready with consumer ready", {31'h0, in_ready}, 32'h1);
    @(negedge clk);

    // Corner keys back to back
    foreach (corners[i]) send(corners[i]);

    // Random keys under random back-pressure and random gaps
    rnd_ready = 1'b1;
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0) @(negedge clk);
      send($urandom());
    end
    foreach (corners[i]) send(corners[i]);
    rnd_ready = 1'b0;
    fixed_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 32'h0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule